// File: doc/BRIEF.md
# Single-Wire Bus Timing Master

This block is the host side of a one-wire, open-drain serial bus. A controller issues one command at a time: a bus reset that also checks for a responding device, a byte write, or a byte read. The block produces every phase of each bit slot by counting clock cycles. All durations are given in microseconds and scaled by the parameter `CYC_PER_US` (default 50). The bus is never driven high. The block only asserts `ow_drive_low`, which enables an external pull-down, and it reads the line back through `ow_in`. That input passes through a two-flop synchronizer before it is used.

Control is a single enumerated state machine. The states are:

- `ST_IDLE`: waiting for a command.
- `ST_RST_LOW`: reset pulse, line driven low.
- `ST_RST_WAIT`: wait before the presence sample.
- `ST_RST_RECOV`: recovery after the presence sample.
- `ST_SLOT_GAP`: recovery gap at the start of each bit slot, line released.
- `ST_SLOT_LOW`: the low pulse that opens the slot.
- `ST_WR_HOLD`: the data part of a write slot.
- `ST_RD_WAIT`: the wait between release and the read sample.
- `ST_RD_TAIL`: the tail of a read slot.

The transitions are:

- `ST_IDLE` goes to `ST_RST_LOW` on a reset opcode, or to `ST_SLOT_GAP` on a write or read opcode.
- The reset phases run in order: `ST_RST_LOW`, then `ST_RST_WAIT`, then `ST_RST_RECOV`, then `ST_IDLE`.
- A slot starts with `ST_SLOT_GAP`, then `ST_SLOT_LOW`.
- From `ST_SLOT_LOW`, a write goes to `ST_WR_HOLD` and a read goes to `ST_RD_WAIT`. `ST_RD_WAIT` is followed by `ST_RD_TAIL`.
- The last state of each slot (`ST_WR_HOLD` or `ST_RD_TAIL`) returns to `ST_SLOT_GAP`, or to `ST_IDLE` after the eighth bit.
- Every state other than `ST_IDLE` leaves when its timer runs out.

Top module: `onewire_master`

## Requirements
- R1: After reset, `busy`, `done`, `ow_drive_low` and `presence` are 0 and `rx_data` is 0x00.
- R2: A reset command drives the line low for exactly 500 µs (500·CYC_PER_US cycles) as a single pulse, then releases it.
- R3: The line is sampled 60 µs after the reset pulse ends. A low level sets `presence` to 1 and a high level sets it to 0. `presence` changes at no other time.
- R4: A reset command then waits a further 500 µs, so `busy` stays high for exactly 1060·CYC_PER_US cycles.
- R5: A write sends `cmd_data` least-significant bit first. Each of the eight slots is a 3 µs released gap, a 3 µs low pulse and a 60 µs data phase, so `busy` lasts 528·CYC_PER_US cycles.
- R6: In a write slot, a 1 bit releases the line for the data phase, giving a 3 µs low pulse. A 0 bit keeps it low, giving a 63 µs low pulse.
- R7: A read runs eight slots. Each slot has a 3 µs gap, a 1 µs low pulse, a sample 10 µs after release and a 60 µs tail, so `busy` lasts 592·CYC_PER_US cycles. Each sample enters at bit 7 of a right-shifting register, so the first bit received ends in bit 0. `rx_data` changes only in the cycle `done` is high.
- R8: A command presented while `busy` is high is ignored. The running operation keeps its timing and result.
- R9: Opcodes are 01 reset, 10 write and 11 read. Opcode 00 with `cmd_valid` is ignored: `busy` stays low and no `done` follows.
- R10: `done` is high for exactly one cycle, in the first cycle with `busy` low after a command. `busy` is high from the cycle after acceptance until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, taken only while idle |
| cmd_op | input | 2 | Opcode: 01 reset, 10 write, 11 read, 00 none |
| cmd_data | input | 8 | Byte to transmit for a write |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| presence | output | 1 | Result of the last presence sample |
| rx_data | output | 8 | Byte received by the last read |
| ow_drive_low | output | 1 | Enables the external pull-down on the bus |
| ow_in | input | 1 | Bus level as seen by the block |

## Verification
A wrong state or timer value shows up first as a low pulse on the bus with the wrong width. The bench measures the width of every pulse, so the error is caught within one bit slot, or within the 500 µs reset pulse. A wrong shift or bit counter gives a wrong byte: the model device records this on a write, and `rx_data` shows it on a read. A wrong slot count changes how long `busy` stays high. Both of these are compared when `done` arrives, at most about 1 ms after the command. A premature or ignored return to idle appears as a `done` that the scoreboard did not expect, or as a missing `done` caught by the watchdog.

// File: rtl/onewire_pkg.sv
package onewire_pkg;

    localparam logic [1:0] OP_NOP   = 2'b00;
    localparam logic [1:0] OP_RESET = 2'b01;
    localparam logic [1:0] OP_WRITE = 2'b10;
    localparam logic [1:0] OP_READ  = 2'b11;

    // phase lengths in microseconds
    localparam int RST_LOW_US   = 500;
    localparam int PRES_WAIT_US = 60;
    localparam int RST_RECOV_US = 500;
    localparam int GAP_US       = 3;
    localparam int WR_LOW_US    = 3;
    localparam int RD_LOW_US    = 1;
    localparam int WR_HOLD_US   = 60;
    localparam int RD_WAIT_US   = 10;
    localparam int RD_TAIL_US   = 60;
    localparam int MAX_US       = 500;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RST_LOW,
        ST_RST_WAIT,
        ST_RST_RECOV,
        ST_SLOT_GAP,
        ST_SLOT_LOW,
        ST_WR_HOLD,
        ST_RD_WAIT,
        ST_RD_TAIL
    } ow_state_e;

endpackage

// File: rtl/onewire_sync.sv
module onewire_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/onewire_timer.sv
module onewire_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/onewire_shifter.sv
module onewire_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         sin,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (shift) begin
            q <= {sin, q[W-1:1]};
        end
    end
endmodule

// File: rtl/onewire_master.sv
module onewire_master
    import onewire_pkg::*;
#(
    parameter int CYC_PER_US  = 50,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              busy,
    output logic              done,
    output logic              presence,
    output logic [DATA_W-1:0] rx_data,
    output logic              ow_drive_low,
    input  logic              ow_in
);
    localparam int CNT_W = $clog2(MAX_US * CYC_PER_US + 1);
    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    ow_state_e          state, nxt;
    logic               is_read;
    logic [BIT_W-1:0]   bit_cnt;
    logic               tm_load, tm_expired;
    logic [CNT_W-1:0]   tm_val;
    logic               line_s;
    logic               sh_load, sh_shift, sh_in;
    logic [DATA_W-1:0]  sh_q;
    logic               last_bit;
    logic               done_q;
    logic               pres_q;
    logic [DATA_W-1:0]  rx_q;

    function automatic logic [CNT_W-1:0] dur_cycles(ow_state_e s, logic rd);
        int us;
        unique case (s)
            ST_RST_LOW:   us = RST_LOW_US;
            ST_RST_WAIT:  us = PRES_WAIT_US;
            ST_RST_RECOV: us = RST_RECOV_US;
            ST_SLOT_GAP:  us = GAP_US;
            ST_SLOT_LOW:  us = rd ? RD_LOW_US : WR_LOW_US;
            ST_WR_HOLD:   us = WR_HOLD_US;
            ST_RD_WAIT:   us = RD_WAIT_US;
            ST_RD_TAIL:   us = RD_TAIL_US;
            default:      us = 0;
        endcase
        if (us == 0) begin
            return '0;
        end
        return CNT_W'(us * CYC_PER_US - 1);
    endfunction

    onewire_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ow_in),
        .q     (line_s)
    );

    onewire_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tm_load),
        .load_val (tm_val),
        .expired  (tm_expired)
    );

    onewire_shifter #(.W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .load_val (cmd_op == OP_WRITE ? cmd_data : '0),
        .shift    (sh_shift),
        .sin      (sh_in),
        .q        (sh_q)
    );

    assign last_bit = (bit_cnt == LAST_BIT);

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    unique case (cmd_op)
                        OP_RESET: nxt = ST_RST_LOW;
                        OP_WRITE: nxt = ST_SLOT_GAP;
                        OP_READ:  nxt = ST_SLOT_GAP;
                        default:  nxt = ST_IDLE;
                    endcase
                end
            end
            ST_RST_LOW:   if (tm_expired) nxt = ST_RST_WAIT;
            ST_RST_WAIT:  if (tm_expired) nxt = ST_RST_RECOV;
            ST_RST_RECOV: if (tm_expired) nxt = ST_IDLE;
            ST_SLOT_GAP:  if (tm_expired) nxt = ST_SLOT_LOW;
            ST_SLOT_LOW:  if (tm_expired) nxt = is_read ? ST_RD_WAIT : ST_WR_HOLD;
            ST_WR_HOLD:   if (tm_expired) nxt = last_bit ? ST_IDLE : ST_SLOT_GAP;
            ST_RD_WAIT:   if (tm_expired) nxt = ST_RD_TAIL;
            ST_RD_TAIL:   if (tm_expired) nxt = last_bit ? ST_IDLE : ST_SLOT_GAP;
            default:      nxt = ST_IDLE;
        endcase
    end

    // timer and shifter control
    always_comb begin
        tm_load  = (nxt != state);
        tm_val   = dur_cycles(nxt, (state == ST_IDLE) ? (cmd_op == OP_READ) : is_read);
        sh_load  = (state == ST_IDLE) && (nxt != ST_IDLE);
        sh_shift = tm_expired && ((state == ST_WR_HOLD) || (state == ST_RD_WAIT));
        sh_in    = (state == ST_RD_WAIT) ? line_s : 1'b0;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_read <= 1'b0;
            bit_cnt <= '0;
            done_q  <= 1'b0;
            pres_q  <= 1'b0;
            rx_q    <= '0;
        end else begin
            done_q <= (state != ST_IDLE) && (nxt == ST_IDLE);
            if (sh_load) begin
                is_read <= (cmd_op == OP_READ);
                bit_cnt <= '0;
            end
            if (tm_expired && ((state == ST_WR_HOLD) || (state == ST_RD_TAIL))) begin
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (state == ST_RST_WAIT && tm_expired) begin
                pres_q <= ~line_s;
            end
            if (state == ST_RD_TAIL && tm_expired && last_bit) begin
                rx_q <= sh_q;
            end
        end
    end

    // outputs
    always_comb begin
        busy     = (state != ST_IDLE);
        done     = done_q;
        presence = pres_q;
        rx_data  = rx_q;
        unique case (state)
            ST_RST_LOW:  ow_drive_low = 1'b1;
            ST_SLOT_LOW: ow_drive_low = 1'b1;
            ST_WR_HOLD:  ow_drive_low = ~sh_q[0];
            default:     ow_drive_low = 1'b0;
        endcase
    end

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !(cmd_valid && cmd_op != OP_NOP)) |=> (state == ST_IDLE));
    // R3
    presence_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(presence) |-> ($past(state) == ST_RST_WAIT));
    // R7
    rx_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_data) |-> done);
endmodule

// File: tb/tb_onewire_master.sv
`timescale 1ns/1ps
module tb_onewire_master;
    import onewire_pkg::*;

    localparam int C = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic [7:0] cmd_data = 8'h00;
    logic       busy, done, presence, drv_low;
    logic [7:0] rx_data;
    logic       slv_pull = 1'b0;
    logic       ow_line;

    assign ow_line = ~(drv_low | slv_pull);

    always #2.5 clk = ~clk;

    onewire_master #(.CYC_PER_US(C)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_op       (cmd_op),
        .cmd_data     (cmd_data),
        .busy         (busy),
        .done         (done),
        .presence     (presence),
        .rx_data      (rx_data),
        .ow_drive_low (drv_low),
        .ow_in        (ow_line)
    );

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural device ----------------
    bit       slv_present = 1'b0;
    int       slv_mode = 0;   // 0 none, 1 capture writes, 2 answer reads
    logic [7:0] slv_rd_byte = 8'h00;
    logic [7:0] slv_cap = 8'h00;
    int       rd_idx = 0;
    bit       s_prev = 0, pres_on = 0, slot_on = 0;
    int       s_low_t = 0, pres_t = 0, slot_t = 0;

    always @(posedge clk) begin
        bit fall, rise, pull_p, pull_r;
        if (!rst_n) begin
            s_prev = 0; pres_on = 0; slot_on = 0; s_low_t = 0;
            slv_pull <= 1'b0;
        end else begin
            fall = drv_low && !s_prev;
            rise = !drv_low && s_prev;
            s_prev = drv_low;
            if (drv_low) s_low_t++;
            if (rise) begin
                pres_on = (s_low_t >= 480 * C) && slv_present;
                pres_t = 0;
                s_low_t = 0;
            end else if (pres_on) begin
                pres_t++;
                if (pres_t >= 135 * C) pres_on = 0;
            end
            pull_p = pres_on && (pres_t >= 15 * C);
            if (fall) begin
                slot_on = 1; slot_t = 0;
            end else if (slot_on) begin
                slot_t++;
                if (slot_t >= 40 * C) slot_on = 0;
            end
            pull_r = 0;
            if (slot_on && slv_mode == 2 && rd_idx < 8) begin
                if (slot_t < 15 * C) pull_r = !slv_rd_byte[rd_idx];
                if (slot_t == 15 * C) rd_idx++;
            end
            if (slot_on && slv_mode == 1 && slot_t == 30 * C)
                slv_cap = {ow_line, slv_cap[7:1]};
            slv_pull <= pull_p | pull_r;
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [1:0] op;
        logic [7:0] data;
        bit         exp_pres;
        logic [7:0] exp_rx;
        int         exp_cycles;
    } item_t;

    item_t sb_q[$];
    int    lows[$];
    int    run_cnt = 0;
    int    cur_low = 0;
    bit    done_prev = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (drv_low) cur_low++;
            else if (cur_low > 0) begin
                lows.push_back(cur_low);
                cur_low = 0;
            end
            if (busy) run_cnt++;
            if (done && done_prev) chk(0, "R10", "done longer than one cycle", 2, 1);
            done_prev = done;
            if (done) begin
                if (sb_q.size() == 0) begin
                    chk(0, "R9", "unexpected done", 1, 0);
                end else begin
                    item_t it;
                    it = sb_q.pop_front();
                    chk(run_cnt == it.exp_cycles, (it.op == OP_RESET) ? "R4" :
                        (it.op == OP_WRITE) ? "R5" : "R7", "busy cycles", run_cnt, it.exp_cycles);
                    chk(busy == 1'b0, "R10", "busy during done", busy, 0);
                    if (it.op == OP_RESET) begin
                        chk(presence == it.exp_pres, "R3", "presence", presence, it.exp_pres);
                        chk(lows.size() == 1, "R2", "reset pulse count", lows.size(), 1);
                        if (lows.size() > 0)
                            chk(lows[0] == 500 * C, "R2", "reset low width", lows[0], 500 * C);
                    end else if (it.op == OP_WRITE) begin
                        chk(slv_cap == it.data, "R5", "byte seen by device", slv_cap, it.data);
                        chk(lows.size() == 8, "R6", "write pulse count", lows.size(), 8);
                        for (int i = 0; i < 8 && i < lows.size(); i++)
                            chk(lows[i] == (it.data[i] ? 3 * C : 63 * C), "R6",
                                $sformatf("write bit %0d low width", i), lows[i],
                                it.data[i] ? 3 * C : 63 * C);
                    end else begin
                        chk(rx_data == it.exp_rx, "R7", "rx_data", rx_data, it.exp_rx);
                        chk(lows.size() == 8, "R7", "read pulse count", lows.size(), 8);
                        for (int i = 0; i < 8 && i < lows.size(); i++)
                            chk(lows[i] == C, "R7", $sformatf("read bit %0d low width", i), lows[i], C);
                    end
                end
                run_cnt = 0;
                lows.delete();
            end
        end
    end

    // ---------------- driver ----------------
    task automatic issue(logic [1:0] op, logic [7:0] data, bit pres, logic [7:0] rdb, bit poke);
        item_t it;
        @(negedge clk);
        slv_present = pres;
        slv_rd_byte = rdb;
        rd_idx = 0;
        slv_cap = 8'h00;
        slv_mode = (op == OP_WRITE) ? 1 : (op == OP_READ) ? 2 : 0;
        it.op = op;
        it.data = data;
        it.exp_pres = pres;
        it.exp_rx = rdb;
        it.exp_cycles = (op == OP_RESET) ? 1060 * C : (op == OP_WRITE) ? 528 * C : 592 * C;
        sb_q.push_back(it);
        cmd_valid = 1'b1; cmd_op = op; cmd_data = data;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'b00; cmd_data = 8'h00;
        if (poke) begin
            // R8: commands while busy must not disturb the running one
            repeat (50 * C) @(negedge clk);
            cmd_valid = 1'b1; cmd_op = OP_RESET; cmd_data = 8'hFF;
            @(negedge clk);
            cmd_valid = 1'b1; cmd_op = OP_READ;
            @(negedge clk);
            cmd_valid = 1'b0; cmd_op = 2'b00; cmd_data = 8'h00;
        end
        while (sb_q.size() != 0) @(negedge clk);
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(busy == 0, "R1", "busy after reset", busy, 0);
        chk(done == 0, "R1", "done after reset", done, 0);
        chk(drv_low == 0, "R1", "drive after reset", drv_low, 0);
        chk(presence == 0, "R1", "presence after reset", presence, 0);
        chk(rx_data == 0, "R1", "rx_data after reset", rx_data, 0);

        issue(OP_RESET, 8'h00, 1'b1, 8'h00, 1'b0);   // R2 R3 R4 present
        issue(OP_RESET, 8'h00, 1'b0, 8'h00, 1'b0);   // R3 absent
        issue(OP_WRITE, 8'hA5, 1'b0, 8'h00, 1'b0);   // R5 R6
        issue(OP_WRITE, 8'h00, 1'b0, 8'h00, 1'b0);
        issue(OP_WRITE, 8'hFF, 1'b0, 8'h00, 1'b0);
        issue(OP_READ,  8'h00, 1'b0, 8'h3C, 1'b0);   // R7
        issue(OP_READ,  8'h00, 1'b0, 8'h81, 1'b0);
        issue(OP_WRITE, 8'h6E, 1'b0, 8'h00, 1'b1);   // R8 during write
        issue(OP_READ,  8'h00, 1'b0, 8'hD2, 1'b1);   // R8 during read
        chk(rx_data == 8'hD2, "R8", "rx_data after ignored commands", rx_data, 8'hD2);

        // R9: opcode 00 is ignored
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = OP_NOP; cmd_data = 8'h55;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy == 0, "R9", "busy after nop", busy, 0);
        chk(drv_low == 0, "R9", "drive after nop", drv_low, 0);
        repeat (20) @(negedge clk);
        chk(busy == 0, "R9", "busy later after nop", busy, 0);
        chk(presence == 0, "R9", "presence unchanged after nop", presence, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule